// File: doc/BRIEF.md
# Split-Region Memory Permission Guard

This block sits between one bus master and a small protected memory window. A programmable split point divides the window into a lower and an upper part. Each part carries its own read, write and instruction-fetch enables. Every access that falls inside the window is checked against the enables of the part it lands in. A write that is not allowed never reaches memory. A read or fetch that is not allowed returns zero.

The first violating access is latched into a fault record, which stays frozen until software clears it, and a pending flag is raised. The interrupt line is the pending flag gated by an enable bit. Clearing is a pulse: software sets a clear bit and then drops it again. A sticky lock bit freezes the permission word and itself until the next reset. A parameter selects one of two packings for the fault record: a full word address with access kind and direction, or a compressed form that keeps only the low address bits and adds a high-prefix flag and an atomic flag.

Top module: `splitwin_guard`

## Requirements
- R1: After reset the permission word, control word, lock bit and fault record all read as zero, and `irq` is low.
- R2: An address is inside the window when it is at least `WIN_BASE` and at most `WIN_BASE + 0x2000`, with both ends included. An access outside the window is always allowed: it is never blocked and never raises a fault.
- R3: The split offset is the stored split field times 4. An in-window access whose offset from `WIN_BASE` is below the split offset uses the low enables. An access at or above the split offset, up to and including the top edge, uses the high enables.
- R4: A write needs the write enable of its part. A fetch (`acc_fetch`=1, `acc_wr`=0) needs the fetch enable of its part. A plain read needs the read enable of its part. Any enable combination is legal.
- R5: `mem_we` is `acc_valid & acc_wr & allowed`. `acc_rdata` equals `mem_rdata` when the access is allowed and is zero when it is blocked.
- R6: A blocked access with no fault pending and clear low sets the pending flag at the next clock edge. In the full packing the record holds address bits 31:2 in bits 31:2, bit 1 = 0 for a fetch and 1 for a data access, and bit 0 = 0 for a read and 1 for a write.
- R7: In the compressed packing (`REC_COMPACT`=1), record bits 25:6 hold address bits 21:2. Bit 5 is 1 when address bits 31:22 equal `HI_PREFIX`, and bit 4 is 1 for an atomic access. All other record bits are 0.
- R8: While a fault is pending, later violations leave the record and the pending flag unchanged.
- R9: `irq` equals the pending flag AND the interrupt enable. Dropping the enable lowers `irq` but leaves the pending flag set.
- R10: While the clear bit is 1, the pending flag is forced low and violations are not captured. Capture resumes once the clear bit is written back to 0.
- R11: Writing 1 to the lock bit sets it, and it stays set until reset. While it is set, writes to the permission word and to the lock bit have no effect, but the control word can still be written.
- R12: The register map on `cfg_addr` is: 0 = permission word, 1 = control word, 2 = lock, 3 = fault record (read only). Permission word fields: bit 0 low read, bit 1 low write, bit 2 low fetch, bit 3 high read, bit 4 high write, bit 5 high fetch, bits 18:8 split field. Control word fields: bit 0 enable, bit 1 clear, bit 2 pending (read only). Lock word: bit 0 lock. Bits not listed read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| acc_valid | input | 1 | Master access in this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wr | input | 1 | 1 for a write |
| acc_fetch | input | 1 | 1 for an instruction fetch |
| acc_atomic | input | 1 | 1 for an atomic access |
| mem_rdata | input | DATA_W | Read data from memory |
| acc_rdata | output | DATA_W | Read data returned to the master, zero when blocked |
| mem_we | output | 1 | Write strobe toward memory, low when blocked |
| irq | output | 1 | Fault interrupt |

## Verification
The checking path is driven from a short vector table and then swept over all 64 enable combinations. Each combination is tried with a read, a write and a fetch at four probe points: the bottom edge of the window, the last word below the split, the split word itself and the inclusive top edge. Together these points separate a wrong split comparison from a wrong edge comparison, and a confusion between the kinds of enable. The table also probes one word past each end of the window, which shows whether the window test is inclusive at the top and exclusive outside it. Directed tests then cover the hold of the first record, a violation while clear is held, masking of the interrupt, the lock against both kinds of write, and the compressed record of an atomic write.

// File: rtl/splitwin_pkg.sv
package splitwin_pkg;

  typedef enum logic [1:0] {
    SEL_PERM  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_LOCK  = 2'd2,
    SEL_FAULT = 2'd3
  } reg_sel_e;

  // packed MSB first: lo_rd lands in bit 0
  typedef struct packed {
    logic hi_fx;
    logic hi_wr;
    logic hi_rd;
    logic lo_fx;
    logic lo_wr;
    logic lo_rd;
  } perm_t;

  localparam int PERM_BITS   = 6;
  localparam int SPLIT_LSB   = 8;
  localparam int CTRL_EN     = 0;
  localparam int CTRL_CLR    = 1;
  localparam int CTRL_PEND   = 2;

endpackage

// File: rtl/splitwin_regs.sv
module splitwin_regs
  import splitwin_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int SPLIT_W = 11
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic               pend,
  input  logic [REG_W-1:0]   rec,
  output perm_t              perm,
  output logic [SPLIT_W-1:0] split_idx,
  output logic               irq_en,
  output logic               clr,
  output logic               lock,
  output logic [REG_W-1:0]   cfg_rdata
);

  perm_t              perm_q, perm_n;
  logic [SPLIT_W-1:0] split_q, split_n;
  logic               en_q, en_n;
  logic               clr_q, clr_n;
  logic               lock_q, lock_n;
  reg_sel_e           sel;

  assign sel = reg_sel_e'(cfg_addr);

  // next state of the writable registers
  always_comb begin
    perm_n  = perm_q;
    split_n = split_q;
    en_n    = en_q;
    clr_n   = clr_q;
    lock_n  = lock_q;
    unique case (sel)
      SEL_PERM: begin
        if (!lock_q) begin
          perm_n  = perm_t'(cfg_wdata[PERM_BITS-1:0]);
          split_n = cfg_wdata[SPLIT_LSB +: SPLIT_W];
        end
      end
      SEL_CTRL: begin
        en_n  = cfg_wdata[CTRL_EN];
        clr_n = cfg_wdata[CTRL_CLR];
      end
      SEL_LOCK:  lock_n = lock_q | cfg_wdata[0];
      SEL_FAULT: ;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      perm_q  <= '0;
      split_q <= '0;
      en_q    <= 1'b0;
      clr_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else if (cfg_we) begin
      perm_q  <= perm_n;
      split_q <= split_n;
      en_q    <= en_n;
      clr_q   <= clr_n;
      lock_q  <= lock_n;
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    unique case (sel)
      SEL_PERM: begin
        cfg_rdata[PERM_BITS-1:0]       = perm_q;
        cfg_rdata[SPLIT_LSB +: SPLIT_W] = split_q;
      end
      SEL_CTRL: begin
        cfg_rdata[CTRL_EN]   = en_q;
        cfg_rdata[CTRL_CLR]  = clr_q;
        cfg_rdata[CTRL_PEND] = pend;
      end
      SEL_LOCK:  cfg_rdata[0] = lock_q;
      SEL_FAULT: cfg_rdata = rec;
      default:   cfg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  assign perm      = perm_q;
  assign split_idx = split_q;
  assign irq_en    = en_q;
  assign clr       = clr_q;
  assign lock      = lock_q;

endmodule

// File: rtl/splitwin_check.sv
module splitwin_check
  import splitwin_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h4000_0000,
  parameter int                WIN_BYTES = 32'h2000,
  parameter int                SPLIT_W   = 11
) (
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_wr,
  input  logic               acc_fetch,
  input  perm_t              perm,
  input  logic [SPLIT_W-1:0] split_idx,
  output logic               allowed,
  output logic               viol
);

  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(WIN_BYTES);

  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] split_offs;
  logic              in_win;
  logic              upper;
  logic              en_rd, en_wr, en_fx;
  logic              grant;

  assign offs       = acc_addr - WIN_BASE;
  assign split_offs = ADDR_W'(split_idx) << 2;
  assign in_win     = (acc_addr >= WIN_BASE) && (offs <= WIN_SPAN);
  assign upper      = (offs >= split_offs);

  always_comb begin
    if (upper) begin
      en_rd = perm.hi_rd;
      en_wr = perm.hi_wr;
      en_fx = perm.hi_fx;
    end else begin
      en_rd = perm.lo_rd;
      en_wr = perm.lo_wr;
      en_fx = perm.lo_fx;
    end
    if (acc_wr)         grant = en_wr;
    else if (acc_fetch) grant = en_fx;
    else                grant = en_rd;
  end

  assign allowed = !in_win || grant;
  assign viol    = acc_valid && !allowed;

endmodule

// File: rtl/splitwin_fault.sv
module splitwin_fault #(
  parameter int                  ADDR_W      = 32,
  parameter bit                  REC_COMPACT = 1'b0,
  parameter logic [ADDR_W-23:0]  HI_PREFIX   = 10'h100
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              viol,
  input  logic              clr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              acc_fetch,
  input  logic              acc_atomic,
  output logic              pend,
  output logic [ADDR_W-1:0] rec
);

  localparam int CMP_LSB  = 2;
  localparam int CMP_MSB  = 21;
  localparam int CMP_POS  = 6;
  localparam int CMP_W    = CMP_MSB - CMP_LSB + 1;
  localparam int HIFLAG   = 5;
  localparam int ATOMFLAG = 4;

  logic [ADDR_W-1:0] packed_rec;
  logic [ADDR_W-1:0] rec_q, rec_n;
  logic              pend_q, pend_n;
  logic              upd;

  generate
    if (REC_COMPACT) begin : g_compact
      always_comb begin
        packed_rec                     = '0;
        packed_rec[CMP_POS +: CMP_W]   = acc_addr[CMP_MSB:CMP_LSB];
        packed_rec[HIFLAG]             = (acc_addr[ADDR_W-1:CMP_MSB+1] == HI_PREFIX);
        packed_rec[ATOMFLAG]           = acc_atomic;
      end
      logic unused_cmp;
      assign unused_cmp = ^{acc_addr[CMP_LSB-1:0], acc_wr, acc_fetch};
    end else begin : g_full
      assign packed_rec = {acc_addr[ADDR_W-1:2], ~acc_fetch | acc_wr, acc_wr};
      logic unused_full;
      assign unused_full = ^{acc_addr[1:0], acc_atomic};
    end
  endgenerate

  always_comb begin
    pend_n = pend_q;
    rec_n  = rec_q;
    if (clr) begin
      pend_n = 1'b0;
    end else if (viol && !pend_q) begin
      pend_n = 1'b1;
      rec_n  = packed_rec;
    end
  end

  assign upd = clr | (viol & ~pend_q);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_q <= 1'b0;
      rec_q  <= '0;
    end else if (upd) begin
      pend_q <= pend_n;
      rec_q  <= rec_n;
    end
  end

  assign pend = pend_q;
  assign rec  = rec_q;

endmodule

// File: rtl/splitwin_guard.sv
module splitwin_guard
  import splitwin_pkg::*;
#(
  parameter int                 ADDR_W      = 32,
  parameter int                 DATA_W      = 32,
  parameter logic [ADDR_W-1:0]  WIN_BASE    = 32'h4000_0000,
  parameter int                 WIN_BYTES   = 32'h2000,
  parameter bit                 REC_COMPACT = 1'b0,
  parameter logic [ADDR_W-23:0] HI_PREFIX   = 10'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              acc_fetch,
  input  logic              acc_atomic,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              mem_we,
  output logic              irq
);

  localparam int SPLIT_W = $clog2(WIN_BYTES) - 2;

  logic [1:0]         rs_q;
  logic               rst_s;
  perm_t              perm_w;
  logic [SPLIT_W-1:0] split_w;
  logic               en_w, clr_w, lock_w;
  logic               pend_w;
  logic [31:0]        rec_w;
  logic               allowed_w, viol_w;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  splitwin_regs #(.REG_W(32), .SPLIT_W(SPLIT_W)) u_regs (
    .clk(clk), .rst_sn(rst_s), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pend(pend_w), .rec(rec_w), .perm(perm_w),
    .split_idx(split_w), .irq_en(en_w), .clr(clr_w), .lock(lock_w),
    .cfg_rdata(cfg_rdata)
  );

  splitwin_check #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
                   .SPLIT_W(SPLIT_W)) u_check (
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_fetch(acc_fetch), .perm(perm_w), .split_idx(split_w),
    .allowed(allowed_w), .viol(viol_w)
  );

  splitwin_fault #(.ADDR_W(ADDR_W), .REC_COMPACT(REC_COMPACT),
                   .HI_PREFIX(HI_PREFIX)) u_fault (
    .clk(clk), .rst_sn(rst_s), .viol(viol_w), .clr(clr_w),
    .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_fetch(acc_fetch),
    .acc_atomic(acc_atomic), .pend(pend_w), .rec(rec_w)
  );

  assign mem_we    = acc_valid & acc_wr & allowed_w;
  assign acc_rdata = allowed_w ? mem_rdata : '0;
  assign irq       = pend_w & en_w;

endmodule

// File: rtl/splitwin_guard_chk.sv
module splitwin_guard_chk (
  input logic        clk,
  input logic        rst_s,
  input logic        acc_valid,
  input logic        acc_wr,
  input logic        mem_we,
  input logic        pend,
  input logic        clr,
  input logic        lock,
  input logic [31:0] rec,
  input logic [31:0] cfg_perm
);

  // R6
  blocked_write_capture_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc_valid && acc_wr && !mem_we && !pend && !clr) |=> pend);

  // R8
  record_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    pend |=> $stable(rec));

  // R10
  clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_s)
    clr |=> !pend);

  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
    lock |=> lock);

  // R11
  perm_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s)
    lock |=> $stable(cfg_perm));

endmodule

bind splitwin_guard splitwin_guard_chk u_chk (
  .clk(clk), .rst_s(rst_s), .acc_valid(acc_valid), .acc_wr(acc_wr),
  .mem_we(mem_we), .pend(pend_w), .clr(clr_w), .lock(lock_w),
  .rec(rec_w), .cfg_perm({13'd0, split_w, 2'b00, perm_w})
);

// File: tb/splitwin_guard_bench.sv
`timescale 1ns/1ps
module splitwin_guard_bench;

  localparam logic [31:0] BASE      = 32'h4000_0000;
  localparam logic [31:0] SPLIT_IDX = 32'h400;
  localparam logic [31:0] MEMD      = 32'hA5A5_1234;

  typedef struct packed {
    logic [5:0]  perm;
    logic [31:0] addr;
    logic        wr;
    logic        fx;
    logic        ok;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{6'b000001, 32'h4000_0FFC, 1'b0, 1'b0, 1'b1},
    '{6'b000001, 32'h4000_1000, 1'b0, 1'b0, 1'b0},
    '{6'b001000, 32'h4000_1000, 1'b0, 1'b0, 1'b1},
    '{6'b001000, 32'h4000_0FFC, 1'b0, 1'b0, 1'b0},
    '{6'b000010, 32'h4000_0000, 1'b1, 1'b0, 1'b1},
    '{6'b000010, 32'h4000_2000, 1'b1, 1'b0, 1'b0},
    '{6'b010000, 32'h4000_2000, 1'b1, 1'b0, 1'b1},
    '{6'b010000, 32'h4000_2004, 1'b1, 1'b0, 1'b1},
    '{6'b000000, 32'h3FFF_FFFC, 1'b0, 1'b0, 1'b1},
    '{6'b000100, 32'h4000_0010, 1'b0, 1'b1, 1'b1},
    '{6'b000001, 32'h4000_0010, 1'b0, 1'b1, 1'b0},
    '{6'b100000, 32'h4000_1FFC, 1'b0, 1'b1, 1'b1},
    '{6'b000000, 32'h4000_1FFC, 1'b0, 1'b0, 1'b0},
    '{6'b111111, 32'h4000_1000, 1'b1, 1'b0, 1'b1},
    '{6'b101111, 32'h4000_1000, 1'b1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata, cmp_cfg_rdata;
  logic        acc_valid, acc_wr, acc_fetch, acc_atomic;
  logic [31:0] acc_addr;
  logic [31:0] acc_rdata, cmp_acc_rdata;
  logic        mem_we, cmp_mem_we, irq, cmp_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  splitwin_guard u_splitwin_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_fetch(acc_fetch),
    .acc_atomic(acc_atomic), .mem_rdata(MEMD), .acc_rdata(acc_rdata),
    .mem_we(mem_we), .irq(irq)
  );

  splitwin_guard #(.REC_COMPACT(1'b1)) u_splitwin_guard_cmp (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cmp_cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_fetch(acc_fetch),
    .acc_atomic(acc_atomic), .mem_rdata(MEMD), .acc_rdata(cmp_acc_rdata),
    .mem_we(cmp_mem_we), .irq(cmp_irq)
  );

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit model_ok(input logic [5:0] p, input logic [31:0] a,
                                  input bit wr, input bit fx);
    logic [2:0] en;
    if (a < BASE || (a - BASE) > 32'h2000) return 1'b1;
    en = ((a - BASE) >= (SPLIT_IDX << 2)) ? p[5:3] : p[2:0];
    if (wr) return en[1];
    if (fx) return en[2];
    return en[0];
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic poke(input logic [31:0] a, input bit wr, input bit fx, input bit at);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_wr = wr; acc_fetch = fx; acc_atomic = at;
    @(negedge clk);
    acc_valid = 1'b0; acc_wr = 1'b0; acc_fetch = 1'b0; acc_atomic = 1'b0;
  endtask

  task automatic clear_fault();
    cfg_write(2'd1, 32'h2);
    cfg_write(2'd1, 32'h0);
  endtask

  task automatic run_one(input logic [5:0] p, input logic [31:0] a, input bit wr,
                         input bit fx, input bit exp_ok, input string tag);
    logic [31:0] d;
    cfg_write(2'd0, (SPLIT_IDX << 8) | {26'd0, p});
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_wr = wr; acc_fetch = fx; acc_atomic = 1'b0;
    #1;
    // R4 R5: gating of the write strobe and of the read data
    chk_eq({tag, " R4/R5 mem_we"}, {31'd0, mem_we}, {31'd0, wr & exp_ok});
    chk_eq({tag, " R5 acc_rdata"}, acc_rdata, exp_ok ? MEMD : 32'h0);
    @(negedge clk);
    acc_valid = 1'b0; acc_wr = 1'b0; acc_fetch = 1'b0;
    read_reg(2'd1, d);
    chk_eq({tag, " R6 pending"}, {31'd0, d[2]}, {31'd0, !exp_ok});
    if (!exp_ok) begin
      read_reg(2'd3, d);
      chk_eq({tag, " R6 record"}, d, {a[31:2], !fx || wr, wr});
      clear_fault();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_wr = 1'b0; acc_fetch = 1'b0; acc_atomic = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int r = 0; r < 4; r++) begin
      read_reg(2'(r), d);
      chk_eq($sformatf("R1 reg %0d after reset", r), d, 32'h0);
    end
    chk_eq("R1 irq after reset", {31'd0, irq}, 32'h0);

    // R12: field positions and unused bits
    cfg_write(2'd0, 32'hFFFF_FFFF);
    read_reg(2'd0, d);
    chk_eq("R12 perm word all ones", d, 32'h0007_FF3F);
    cfg_write(2'd1, 32'hFFFF_FFF9);
    read_reg(2'd1, d);
    chk_eq("R12 ctrl word", d, 32'h0000_0001);
    cfg_write(2'd1, 32'h0);

    // vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < 15; i++)
      run_one(VEC[i].perm, VEC[i].addr, VEC[i].wr, VEC[i].fx, VEC[i].ok,
              $sformatf("R2/R3 vec %0d", i));

    // sweep all enable combinations at edges and split (R3 R4)
    for (int p = 0; p < 64; p++) begin
      for (int k = 0; k < 3; k++) begin
        for (int s = 0; s < 4; s++) begin
          logic [31:0] a;
          case (s)
            0: a = BASE;
            1: a = BASE + 32'h0FFC;
            2: a = BASE + 32'h1000;
            default: a = BASE + 32'h2000;
          endcase
          run_one(6'(p), a, k == 1, k == 2, model_ok(6'(p), a, k == 1, k == 2),
                  $sformatf("R3 sweep p=%0d k=%0d s=%0d", p, k, s));
        end
      end
    end

    // R8: first record held
    cfg_write(2'd0, SPLIT_IDX << 8);
    poke(BASE + 32'h20, 1'b0, 1'b0, 1'b0);
    poke(BASE + 32'h1800, 1'b1, 1'b0, 1'b0);
    read_reg(2'd3, d);
    chk_eq("R8 record keeps first fault", d, 32'h4000_0022);
    read_reg(2'd1, d);
    chk_eq("R8 pending stays", {31'd0, d[2]}, 32'h1);
    clear_fault();

    // R7: compressed record of an atomic write
    poke(BASE + 32'h1000, 1'b1, 1'b0, 1'b1);
    cfg_addr = 2'd3;
    #1;
    chk_eq("R7 compressed record", cmp_cfg_rdata, 32'h0001_0030);
    clear_fault();

    // R9: interrupt gating
    cfg_write(2'd1, 32'h1);
    poke(BASE + 32'h40, 1'b0, 1'b1, 1'b0);
    chk_eq("R9 irq with enable", {31'd0, irq}, 32'h1);
    cfg_write(2'd1, 32'h0);
    chk_eq("R9 irq masked", {31'd0, irq}, 32'h0);
    read_reg(2'd1, d);
    chk_eq("R9 pending kept when masked", {31'd0, d[2]}, 32'h1);
    clear_fault();

    // R10: clear held blocks capture
    cfg_write(2'd1, 32'h2);
    poke(BASE + 32'h10, 1'b0, 1'b0, 1'b0);
    read_reg(2'd1, d);
    chk_eq("R10 no capture while clear", {31'd0, d[2]}, 32'h0);
    cfg_write(2'd1, 32'h0);
    read_reg(2'd1, d);
    chk_eq("R10 still idle after release", {31'd0, d[2]}, 32'h0);
    poke(BASE + 32'h10, 1'b0, 1'b0, 1'b0);
    read_reg(2'd1, d);
    chk_eq("R10 capture resumes", {31'd0, d[2]}, 32'h1);
    clear_fault();

    // R11: lock
    cfg_write(2'd0, 32'h0004_002D);
    cfg_write(2'd2, 32'h1);
    read_reg(2'd2, d);
    chk_eq("R11 lock set", d, 32'h1);
    cfg_write(2'd0, 32'h0000_0012);
    read_reg(2'd0, d);
    chk_eq("R11 perm frozen", d, 32'h0004_002D);
    cfg_write(2'd2, 32'h0);
    read_reg(2'd2, d);
    chk_eq("R11 lock sticky", d, 32'h1);
    cfg_write(2'd1, 32'h1);
    read_reg(2'd1, d);
    chk_eq("R11 ctrl writable when locked", d, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_reg(2'd2, d);
    chk_eq("R11 reset releases lock", d, 32'h0);
    read_reg(2'd0, d);
    chk_eq("R11 reset clears perm", d, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule